// File: doc/BRIEF.md
# Display Reset and Identification Sequencer

This block brings an external display driver chip out of power-up. A single start pulse launches a fixed script. First the block drives a write-protect pin and an active-low reset pin through a timed pattern. It then sends a short series of command and parameter writes over a parallel system bus. These writes unlock register access, wake the chip from deep standby and ask for its identification code. After a long settling wait it performs five reads. The first read is thrown away. The low byte of each of the other four is assembled into a 32-bit identity word.

The identity word is compared with an expected constant. The block then finishes with a one-cycle done pulse and a pass flag. When the identity does not match, the sequence stops with a no-device result and nothing more is sent on the bus. Bus traffic leaves the block as requests to a separate bus engine, which produces the physical strobes. Each request is held until the engine acknowledges it, and read data returns on its own valid strobe.

All waits are given in microseconds and scaled by a clocks-per-microsecond parameter. A bench can therefore shorten them freely.

Top module: `disp_id_seq`

## Requirements
- R1: While reset is asserted, and afterwards until a start pulse arrives, protect_o is low, lcd_rst_n_o is high, req_valid_o is low, done_o is low and id_o is zero.
- R2: A start pulse sampled at a clock edge drives lcd_rst_n_o low at the third edge after it. protect_o rises exactly one cycle after lcd_rst_n_o falls.
- R3: lcd_rst_n_o is released exactly RST_US*CLK_PER_US cycles after protect_o rises. protect_o then falls exactly REL_US*CLK_PER_US cycles after that release.
- R4: The first bus request appears exactly SET_US*CLK_PER_US cycles after protect_o falls. The writes, in order, are command 0xB0, parameter 0x00, command 0xB1, parameter 0x00, command 0xBF.
- R5: req_kind_o encodes 0 = command write, 1 = parameter write, 2 = read. Command writes have req_rs_o low and an 8-bit value in req_data_o[7:0] with bits [17:8] zero. Parameter writes and reads have req_rs_o high.
- R6: Once raised, req_valid_o, req_kind_o and req_data_o stay unchanged until req_ready_i is high at a clock edge.
- R7: The first read request becomes visible exactly QRY_US*CLK_PER_US cycles after the edge at which command 0xBF is accepted.
- R8: Exactly five reads are issued. The data of the first is discarded. The bytes returned by reads two to five fill id_o from bit 31 down to bit 0.
- R9: After the fifth read's data is captured, done_o pulses for one cycle. pass_o is high when id_o equals ID_WORD (default 0x01221517) and low otherwise. A failed check is followed by no further bus request.
- R10: A start pulse while a sequence is in progress has no effect: exactly one done pulse and ten bus transactions result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Launch pulse |
| protect_o | output | 1 | Write-protect pin to the display chip |
| lcd_rst_n_o | output | 1 | Active-low reset pin to the display chip |
| req_valid_o | output | 1 | Bus request present |
| req_kind_o | output | 2 | 0 command write, 1 parameter write, 2 read |
| req_rs_o | output | 1 | Register-select level for the request |
| req_data_o | output | 18 | Write value |
| req_ready_i | input | 1 | Bus engine accepts the request this edge |
| rd_valid_i | input | 1 | Read data strobe |
| rd_data_i | input | 8 | Low byte of the read word |
| done_o | output | 1 | One-cycle end-of-sequence pulse |
| pass_o | output | 1 | Identity matched, valid from done_o on |
| id_o | output | 32 | Assembled identity word |

## Verification
The sequence is first run with a bus engine that accepts at once and a dummy read value unlike any identity byte. A mix-up between the dummy read and the first ID byte would then show up in id_o. A second run stalls every acceptance by three cycles, makes the dummy read equal the first ID byte and repeats start mid-sequence. It separates correct request holding and start masking from designs that drop requests or restart. A third run returns two ID bytes swapped. Only a byte-order-true packer with a full compare reports no-device there, and the bus must then stay quiet. Pin edges and the first requests are time-stamped to confirm every wait to the exact cycle.

// File: rtl/disp_id_pkg.sv
package disp_id_pkg;

  typedef enum logic [1:0] {
    OP_CMD = 2'd0,
    OP_PRM = 2'd1,
    OP_RD  = 2'd2
  } bus_op_e;

  typedef enum logic [3:0] {
    S_IDLE, S_PROT_LO, S_RST_LO, S_PROT_HI,
    S_W_RST, S_W_REL, S_W_SET,
    S_WR, S_W_QRY, S_RD, S_RD_WAIT, S_CMP
  } seq_st_e;

  localparam logic [7:0] CMD_UNLOCK = 8'hB0;
  localparam logic [7:0] CMD_WAKE   = 8'hB1;
  localparam logic [7:0] CMD_IDQ    = 8'hBF;

  localparam int unsigned WR_STEPS = 5;
  localparam int unsigned RD_COUNT = 5;

endpackage

// File: rtl/disp_id_timer.sv
module disp_id_timer #(
  parameter int unsigned CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_i,
  input  logic [CW-1:0] len_i,
  output logic          zero_o
);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  assign cnt_en = load_i | (cnt_q != '0);

  always_comb begin
    if (load_i) cnt_d = len_i - CW'(1);
    else        cnt_d = cnt_q - CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign zero_o = (cnt_q == '0);

endmodule

// File: rtl/disp_id_packer.sv
module disp_id_packer #(
  parameter int unsigned IDW = 32,
  parameter int unsigned BW  = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           clr_i,
  input  logic           cap_i,
  input  logic [BW-1:0]  byte_i,
  output logic [IDW-1:0] word_o
);

  logic [IDW-1:0] word_q, word_d;
  logic           word_en;

  assign word_en = clr_i | cap_i;

  always_comb begin
    if (clr_i) word_d = '0;
    else       word_d = {word_q[IDW-BW-1:0], byte_i};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       word_q <= '0;
    else if (word_en) word_q <= word_d;
  end

  assign word_o = word_q;

endmodule

// File: rtl/disp_id_fsm.sv
module disp_id_fsm
  import disp_id_pkg::*;
#(
  parameter int unsigned CW      = 8,
  parameter int unsigned PW      = 18,
  parameter int unsigned LEN_RST = 4,
  parameter int unsigned LEN_REL = 4,
  parameter int unsigned LEN_SET = 4,
  parameter int unsigned LEN_QRY = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic          zero_i,
  input  logic          req_ready_i,
  input  logic          rd_valid_i,
  input  logic          match_i,
  output logic          load_o,
  output logic [CW-1:0] len_o,
  output logic          protect_o,
  output logic          lcd_rst_n_o,
  output logic          req_valid_o,
  output bus_op_e       req_kind_o,
  output logic          req_rs_o,
  output logic [PW-1:0] req_data_o,
  output logic          clr_o,
  output logic          cap_o,
  output logic          done_o,
  output logic          pass_o
);

  localparam int unsigned SW = $clog2(WR_STEPS);
  localparam int unsigned RW = $clog2(RD_COUNT);
  localparam logic [SW-1:0] WR_LAST = SW'(WR_STEPS - 1);
  localparam logic [RW-1:0] RD_LAST = RW'(RD_COUNT - 1);

  seq_st_e       st_q, st_d;
  logic [SW-1:0] step_q, step_d;
  logic [RW-1:0] rdn_q, rdn_d;
  logic          prot_q, prot_d, rstn_q, rstn_d;
  logic          done_q, done_d, pass_q, pass_d;
  logic [7:0]    wr_byte;

  // write script: even steps are commands, odd steps their single parameter
  always_comb begin
    case (step_q)
      SW'(0):  wr_byte = CMD_UNLOCK;
      SW'(2):  wr_byte = CMD_WAKE;
      SW'(4):  wr_byte = CMD_IDQ;
      default: wr_byte = 8'h00;
    endcase
  end

  assign req_valid_o = (st_q == S_WR) || (st_q == S_RD);
  assign req_kind_o  = (st_q == S_RD) ? OP_RD : (step_q[0] ? OP_PRM : OP_CMD);
  assign req_rs_o    = (st_q == S_RD) || (step_q[0] == 1'b1);
  assign req_data_o  = (st_q == S_WR) ? PW'(wr_byte) : '0;

  always_comb begin
    st_d   = st_q;
    step_d = step_q;
    rdn_d  = rdn_q;
    prot_d = prot_q;
    rstn_d = rstn_q;
    done_d = 1'b0;
    pass_d = pass_q;
    load_o = 1'b0;
    len_o  = '0;
    clr_o  = 1'b0;
    cap_o  = 1'b0;
    case (st_q)
      S_IDLE: if (start_i) begin
        st_d = S_PROT_LO; pass_d = 1'b0; clr_o = 1'b1;
      end
      S_PROT_LO: begin prot_d = 1'b0; st_d = S_RST_LO; end
      S_RST_LO:  begin rstn_d = 1'b0; st_d = S_PROT_HI; end
      S_PROT_HI: begin
        prot_d = 1'b1; load_o = 1'b1; len_o = CW'(LEN_RST); st_d = S_W_RST;
      end
      S_W_RST: if (zero_i) begin
        rstn_d = 1'b1; load_o = 1'b1; len_o = CW'(LEN_REL); st_d = S_W_REL;
      end
      S_W_REL: if (zero_i) begin
        prot_d = 1'b0; load_o = 1'b1; len_o = CW'(LEN_SET); st_d = S_W_SET;
      end
      S_W_SET: if (zero_i) begin step_d = '0; st_d = S_WR; end
      S_WR: if (req_ready_i) begin
        if (step_q == WR_LAST) begin
          load_o = 1'b1; len_o = CW'(LEN_QRY); st_d = S_W_QRY;
        end else begin
          step_d = step_q + SW'(1);
        end
      end
      S_W_QRY: if (zero_i) begin rdn_d = '0; st_d = S_RD; end
      S_RD:    if (req_ready_i) st_d = S_RD_WAIT;
      S_RD_WAIT: if (rd_valid_i) begin
        cap_o = (rdn_q != '0);
        if (rdn_q == RD_LAST) st_d = S_CMP;
        else begin rdn_d = rdn_q + RW'(1); st_d = S_RD; end
      end
      S_CMP: begin done_d = 1'b1; pass_d = match_i; st_d = S_IDLE; end
      default: st_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= S_IDLE;
      step_q <= '0;
      rdn_q  <= '0;
      prot_q <= 1'b0;
      rstn_q <= 1'b1;
      done_q <= 1'b0;
      pass_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      step_q <= step_d;
      rdn_q  <= rdn_d;
      prot_q <= prot_d;
      rstn_q <= rstn_d;
      done_q <= done_d;
      pass_q <= pass_d;
    end
  end

  assign protect_o   = prot_q;
  assign lcd_rst_n_o = rstn_q;
  assign done_o      = done_q;
  assign pass_o      = pass_q;

endmodule

// File: rtl/disp_id_seq.sv
module disp_id_seq #(
  parameter int unsigned CLK_PER_US = 50,
  parameter int unsigned RST_US     = 1100,
  parameter int unsigned REL_US     = 10,
  parameter int unsigned SET_US     = 20000,
  parameter int unsigned QRY_US     = 50000,
  parameter logic [31:0] ID_WORD    = 32'h0122_1517
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start_i,
  output logic        protect_o,
  output logic        lcd_rst_n_o,
  output logic        req_valid_o,
  output logic [1:0]  req_kind_o,
  output logic        req_rs_o,
  output logic [17:0] req_data_o,
  input  logic        req_ready_i,
  input  logic        rd_valid_i,
  input  logic [7:0]  rd_data_i,
  output logic        done_o,
  output logic        pass_o,
  output logic [31:0] id_o
);
  import disp_id_pkg::*;

  localparam int unsigned PW      = 18;
  localparam int unsigned LEN_RST = RST_US * CLK_PER_US;
  localparam int unsigned LEN_REL = REL_US * CLK_PER_US;
  localparam int unsigned LEN_SET = SET_US * CLK_PER_US;
  localparam int unsigned LEN_QRY = QRY_US * CLK_PER_US;
  localparam int unsigned MAX_A   = (LEN_RST > LEN_REL) ? LEN_RST : LEN_REL;
  localparam int unsigned MAX_B   = (LEN_SET > LEN_QRY) ? LEN_SET : LEN_QRY;
  localparam int unsigned LEN_MAX = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int unsigned CW      = $clog2(LEN_MAX + 1);

  logic          load, zero, clr, cap, match;
  logic [CW-1:0] len;
  bus_op_e       kind;

  disp_id_fsm #(
    .CW(CW), .PW(PW),
    .LEN_RST(LEN_RST), .LEN_REL(LEN_REL), .LEN_SET(LEN_SET), .LEN_QRY(LEN_QRY)
  ) u_fsm (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .zero_i(zero),
    .req_ready_i(req_ready_i), .rd_valid_i(rd_valid_i), .match_i(match),
    .load_o(load), .len_o(len), .protect_o(protect_o), .lcd_rst_n_o(lcd_rst_n_o),
    .req_valid_o(req_valid_o), .req_kind_o(kind), .req_rs_o(req_rs_o),
    .req_data_o(req_data_o), .clr_o(clr), .cap_o(cap),
    .done_o(done_o), .pass_o(pass_o)
  );

  disp_id_timer #(.CW(CW)) u_tmr (
    .clk(clk), .rst_n(rst_n), .load_i(load), .len_i(len), .zero_o(zero)
  );

  disp_id_packer #(.IDW(32), .BW(8)) u_pack (
    .clk(clk), .rst_n(rst_n), .clr_i(clr), .cap_i(cap),
    .byte_i(rd_data_i), .word_o(id_o)
  );

  assign match      = (id_o == ID_WORD);
  assign req_kind_o = kind;

endmodule

// File: rtl/disp_id_chk.sv
module disp_id_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        protect_o,
  input logic        lcd_rst_n_o,
  input logic        req_valid_o,
  input logic [1:0]  req_kind_o,
  input logic        req_rs_o,
  input logic [17:0] req_data_o,
  input logic        req_ready_i,
  input logic        done_o,
  input logic        pass_o
);

  // R2
  prot_after_rst_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(lcd_rst_n_o) |=> protect_o);

  // R3
  release_under_prot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lcd_rst_n_o) |-> protect_o);

  // R5
  cmd_shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid_o && req_kind_o == 2'd0) |-> (!req_rs_o && req_data_o[17:8] == 10'd0));

  // R6
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid_o && !req_ready_i) |=>
      (req_valid_o && $stable(req_kind_o) && $stable(req_data_o)));

  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  // R9
  quiet_after_fail_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !pass_o) |=> !req_valid_o);

endmodule

bind disp_id_seq disp_id_chk u_chk (
  .clk(clk), .rst_n(rst_n), .protect_o(protect_o), .lcd_rst_n_o(lcd_rst_n_o),
  .req_valid_o(req_valid_o), .req_kind_o(req_kind_o), .req_rs_o(req_rs_o),
  .req_data_o(req_data_o), .req_ready_i(req_ready_i),
  .done_o(done_o), .pass_o(pass_o)
);

// File: tb/sim_disp_id_seq.sv
module sim_disp_id_seq;
  localparam int CPU = 3, RST_US = 7, REL_US = 2, SET_US = 5, QRY_US = 4;
  localparam int L_RST = CPU * RST_US, L_REL = CPU * REL_US;
  localparam int L_SET = CPU * SET_US, L_QRY = CPU * QRY_US;

  logic clk = 1'b0, rst_n = 1'b0, start_i = 1'b0;
  logic req_ready_i = 1'b0, rd_valid_i = 1'b0;
  logic [7:0] rd_data_i = 8'h00;
  logic protect_o, lcd_rst_n_o, req_valid_o, req_rs_o, done_o, pass_o;
  logic [1:0] req_kind_o;
  logic [17:0] req_data_o;
  logic [31:0] id_o;

  disp_id_seq #(.CLK_PER_US(CPU), .RST_US(RST_US), .REL_US(REL_US),
    .SET_US(SET_US), .QRY_US(QRY_US)) u0 (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .protect_o(protect_o),
    .lcd_rst_n_o(lcd_rst_n_o), .req_valid_o(req_valid_o), .req_kind_o(req_kind_o),
    .req_rs_o(req_rs_o), .req_data_o(req_data_o), .req_ready_i(req_ready_i),
    .rd_valid_i(rd_valid_i), .rd_data_i(rd_data_i), .done_o(done_o),
    .pass_o(pass_o), .id_o(id_o));

  always #10 clk = ~clk;

  int total = 0, bad = 0, cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  // bus engine model and monitor state
  int stall_cfg = 0, stall_ctr = 0, hold_err = 0, rd_k = 0, n_tx = 0, n_done = 0;
  bit rd_pend = 0, prev_prot = 0, prev_rst = 1, in_stall = 0;
  logic [7:0] rd_bytes [5];
  logic [1:0] tx_kind [16];
  logic [17:0] tx_data [16];
  logic tx_rs [16];
  logic last_pass;
  int t_rst_lo, t_prot_hi, t_rst_hi, t_prot_lo, t_first_req, t_bf, t_first_rd;

  always @(negedge clk) begin
    if (protect_o && !prev_prot) t_prot_hi = cyc;
    if (!protect_o && prev_prot) t_prot_lo = cyc;
    if (!lcd_rst_n_o && prev_rst) t_rst_lo = cyc;
    if (lcd_rst_n_o && !prev_rst) t_rst_hi = cyc;
    prev_prot = protect_o;
    prev_rst = lcd_rst_n_o;
    if (done_o) begin n_done++; last_pass = pass_o; end
    rd_valid_i = 1'b0;
    if (rd_pend) begin
      rd_valid_i = 1'b1; rd_data_i = rd_bytes[rd_k]; rd_k++; rd_pend = 0;
    end
    if (in_stall && !req_valid_o) hold_err++;
    if (req_ready_i) req_ready_i = 1'b0;
    else if (req_valid_o) begin
      if (t_first_req < 0) t_first_req = cyc;
      if (req_kind_o == 2'd2 && t_first_rd < 0) t_first_rd = cyc;
      if (stall_ctr < stall_cfg) begin stall_ctr++; in_stall = 1; end
      else begin
        stall_ctr = 0; in_stall = 0;
        if (n_tx < 16) begin
          tx_kind[n_tx] = req_kind_o; tx_data[n_tx] = req_data_o; tx_rs[n_tx] = req_rs_o;
        end
        if (req_kind_o == 2'd0 && req_data_o == 18'hBF) t_bf = cyc;
        n_tx++;
        req_ready_i = 1'b1;
        if (req_kind_o == 2'd2) rd_pend = 1;
      end
    end
  end

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    // R1 during reset
    chk("R1", "protect in reset", protect_o, 0);
    chk("R1", "lcd reset in reset", lcd_rst_n_o, 1);
    chk("R1", "valid in reset", req_valid_o, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1 idle after reset
    chk("R1", "done idle", done_o, 0);
    chk("R1", "id idle", id_o, 0);
    chk("R1", "valid idle", req_valid_o, 0);
    chk("R1", "lcd reset idle", lcd_rst_n_o, 1);
  endtask

  task automatic run_seq(input string nm, input int stall, input logic [7:0] dmy,
                         input logic [31:0] idw, input bit poke, input bit exp_pass);
    int s0, k;
    logic [7:0] exp_b [5];
    logic [1:0] exp_k [10];
    stall_cfg = stall; stall_ctr = 0; hold_err = 0; rd_k = 0; n_tx = 0; n_done = 0;
    t_first_req = -1; t_first_rd = -1; t_bf = -1; in_stall = 0;
    rd_bytes[0] = dmy; rd_bytes[1] = idw[31:24]; rd_bytes[2] = idw[23:16];
    rd_bytes[3] = idw[15:8]; rd_bytes[4] = idw[7:0];
    exp_b[0] = 8'hB0; exp_b[1] = 8'h00; exp_b[2] = 8'hB1; exp_b[3] = 8'h00; exp_b[4] = 8'hBF;
    for (int i = 0; i < 10; i++) exp_k[i] = (i >= 5) ? 2'd2 : ((i % 2 == 1) ? 2'd1 : 2'd0);
    @(negedge clk); start_i = 1'b1; s0 = cyc;
    @(negedge clk); start_i = 1'b0;
    if (poke) begin
      repeat (25) @(negedge clk);
      start_i = 1'b1; @(negedge clk); start_i = 1'b0;
    end
    k = 0;
    while (n_done == 0 && k < 3000) begin @(negedge clk); k++; end
    repeat (40) @(negedge clk);
    $display("scenario %s", nm);
    chk("R2", "reset fall cycle", t_rst_lo - s0, 3);
    chk("R2", "protect rise after reset fall", t_prot_hi - t_rst_lo, 1);
    chk("R3", "reset hold", t_rst_hi - t_prot_hi, L_RST);
    chk("R3", "protect fall after release", t_prot_lo - t_rst_hi, L_REL);
    chk("R4", "first request delay", t_first_req - t_prot_lo, L_SET);
    chk("R10", "transaction count", n_tx, 10);
    for (int i = 0; i < 10 && i < n_tx; i++) begin
      chk("R5", $sformatf("kind %0d", i), tx_kind[i], exp_k[i]);
      chk("R5", $sformatf("rs %0d", i), tx_rs[i], (exp_k[i] != 2'd0));
      if (i < 5) chk("R4", $sformatf("write value %0d", i), tx_data[i], exp_b[i]);
    end
    chk("R6", "request dropped during stall", hold_err, 0);
    chk("R7", "query wait", t_first_rd - t_bf, L_QRY + 1);
    chk("R8", "packed id", id_o, idw);
    chk("R9", "done pulses", n_done, 1);
    chk("R9", "pass flag", last_pass, exp_pass);
    chk("R9", "bus quiet at end", req_valid_o, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: actual=expired expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    t_reset();
    run_seq("fast accept", 0, 8'hA5, 32'h0122_1517, 1'b0, 1'b1);
    run_seq("stalled bus, repeated start", 3, 8'h01, 32'h0122_1517, 1'b1, 1'b1);
    run_seq("swapped bytes", 1, 8'h00, 32'h0122_1715, 1'b0, 1'b0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule